// File: doc/BRIEF.md
# NAND Hamming ECC Corrector

This block judges one 256-byte data chunk read from NAND flash by comparing two 22-bit Hamming check words. One is the word computed over the data as it was read. The other is the word fetched from the page's spare area. The block XORs them into a syndrome and counts the set syndrome bits, a few bits per clock. It then sorts the outcome into four classes: clean, a flipped bit inside the stored check word, a single data bit that can be repaired, or damage beyond repair. The last class means the erase block should be retired.

For a 512-byte page, the caller sets the two-chunk flag and supplies a second pair of words. The block checks the first half and then the second half. The reported result is the one from the second half, and its byte position is offset by 256.

A small correction port then repairs data on the fly. The caller presents a byte and its offset within the page. The byte comes back with the failing bit inverted only when that offset is the one that was reported.

Top module: `nand_ecc_corrector`

## Requirements
- R1: After reset, status is 00, done and busy are low, err_half, err_byte and err_bit are zero, and fix_out equals fix_in.
- R2: Status is 00 (clean) when the syndrome (computed XOR stored) is zero, or when either word is all zeros. This takes priority over every other class.
- R3: Status is 01 (check-word error) when exactly one syndrome bit is set. In that case the error indices read zero and the correction port passes bytes unchanged.
- R4: Status is 10 (corrected) when exactly 11 syndrome bits are set and (computed[10:0]^computed[21:11]) ^ (stored[10:0]^stored[21:11]) equals 0x7FF. In that case err_byte is syndrome[10:3] and err_bit is syndrome[2:0].
- R5: Every other syndrome is reported as status 11 (uncorrectable, retire the block). This includes eleven set bits where some bit k and bit k+11 are both set.
- R6: fix_out equals fix_in XOR (1 << err_bit) when status is 10 and fix_idx equals {err_half, err_byte}. Otherwise fix_out equals fix_in.
- R7: With two_chunk high, the pair calc1/stored1 is checked after calc0/stored0. The result reflects the second pair only. A repair found there sets err_half, so its page offset is 256 + err_byte.
- R8: done pulses for exactly one cycle per accepted start. With SLICE_W=4 it arrives ceil(22/SLICE_W)+1 = 7 cycles after the start edge for one chunk, and 14 cycles after it for two chunks. busy is high in between.
- R9: A start while busy is ignored. It produces no extra done and does not change the result.
- R10: status and the error indices hold their values from the last done until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check when idle |
| two_chunk | input | 1 | 1: 512-byte page, check both word pairs |
| calc0 | input | 22 | Computed check word, first chunk |
| stored0 | input | 22 | Stored check word, first chunk |
| calc1 | input | 22 | Computed check word, second chunk |
| stored1 | input | 22 | Stored check word, second chunk |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 check-word error, 10 corrected, 11 uncorrectable |
| err_half | output | 1 | Reported error lies in the second chunk |
| err_byte | output | 8 | Failing byte within its chunk |
| err_bit | output | 3 | Failing bit within the byte |
| fix_idx | input | 9 | Page offset of the byte on the correction port |
| fix_in | input | 8 | Byte to be repaired |
| fix_out | output | 8 | Byte after optional repair |

## Verification
The word pairs cover all four classes.

- Identical words and all-zero words check the clean class. This includes an all-zero word whose syndrome has a single set bit, which separates the priority of the zero test from the one-bit test.
- Single-bit syndromes in either field give the check-word class.
- Complement-shaped syndromes at positions 0, 0x4D5 and 0x7FF pin down the byte and bit split at both ends.
- Two bits, all 22 bits, and an eleven-bit pattern with one doubled parity pair tell the popcount rule apart from the pair-disagreement rule.

Two-chunk runs place the repairable error first in one run and second in the other, which shows that only the last half counts and that the 256 offset reaches the correction port.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'b00,
        ST_ECCBIT = 2'b01,
        ST_FIXED  = 2'b10,
        ST_FATAL  = 2'b11
    } ecc_status_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_JUDGE = 2'd2
    } phase_e;

endpackage

// File: rtl/ecc_slice_pop.sv
// Counts the ones in one SLICE_W-bit slice of a word; the slice is picked by sel.
module ecc_slice_pop #(
    parameter int EW      = 22,
    parameter int SLICE_W = 4,
    localparam int NSL    = (EW + SLICE_W - 1) / SLICE_W,
    localparam int PADW   = NSL * SLICE_W,
    localparam int SEL_W  = (NSL > 1) ? $clog2(NSL) : 1,
    localparam int SCW    = $clog2(SLICE_W + 1)
) (
    input  logic [EW-1:0]    word,
    input  logic [SEL_W-1:0] sel,
    output logic [SCW-1:0]   cnt
);

    logic [PADW-1:0]    padded;
    logic [SLICE_W-1:0] slices [NSL];

    always_comb begin
        padded         = '0;
        padded[EW-1:0] = word;
    end

    for (genvar g = 0; g < NSL; g++) begin : g_slice
        assign slices[g] = padded[g*SLICE_W +: SLICE_W];
    end

    always_comb begin
        cnt = '0;
        for (int i = 0; i < SLICE_W; i++) begin
            cnt = cnt + SCW'(slices[sel][i]);
        end
    end

endmodule

// File: rtl/ecc_judge.sv
// Sorts a finished comparison into one of four classes.
module ecc_judge
    import ecc_chk_pkg::*;
#(
    parameter int PAR_W  = 11,
    localparam int EW     = 2 * PAR_W,
    localparam int BYTE_W = PAR_W - 3,
    localparam int CW     = $clog2(EW + 1)
) (
    input  logic [EW-1:0]     calc,
    input  logic [EW-1:0]     stored,
    input  logic [CW-1:0]     ones,
    output ecc_status_e       status,
    output logic [BYTE_W-1:0] byte_idx,
    output logic [2:0]        bit_idx
);

    logic [EW-1:0]    syn;
    logic [PAR_W-1:0] pair_mix;
    logic             any_zero;

    always_comb begin
        syn      = calc ^ stored;
        pair_mix = (calc[PAR_W-1:0] ^ calc[EW-1:PAR_W])
                 ^ (stored[PAR_W-1:0] ^ stored[EW-1:PAR_W]);
        any_zero = (syn == '0) || (calc == '0) || (stored == '0);
        byte_idx = '0;
        bit_idx  = '0;
        if (any_zero) begin
            status = ST_CLEAN;
        end else if (ones == CW'(1)) begin
            status = ST_ECCBIT;
        end else if ((ones == CW'(PAR_W)) && (&pair_mix)) begin
            status   = ST_FIXED;
            byte_idx = syn[PAR_W-1:3];
            bit_idx  = syn[2:0];
        end else begin
            status = ST_FATAL;
        end
    end

endmodule

// File: rtl/ecc_byte_fix.sv
// Inverts the reported bit of a byte whose page offset matches the reported one.
module ecc_byte_fix
    import ecc_chk_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  ecc_status_e      status,
    input  logic [IDX_W-1:0] err_idx,
    input  logic [2:0]       err_bit,
    input  logic [IDX_W-1:0] probe_idx,
    input  logic [7:0]       din,
    output logic [7:0]       dout
);

    logic [7:0] mask;
    logic       hit;

    always_comb begin
        mask = 8'(1) << err_bit;
        hit  = (status == ST_FIXED) && (err_idx == probe_idx);
        dout = hit ? (din ^ mask) : din;
    end

endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
    import ecc_chk_pkg::*;
#(
    parameter int PAR_W   = 11,
    parameter int SLICE_W = 4,
    localparam int EW     = 2 * PAR_W,
    localparam int BYTE_W = PAR_W - 3,
    localparam int IDX_W  = BYTE_W + 1,
    localparam int NSL    = (EW + SLICE_W - 1) / SLICE_W,
    localparam int SEL_W  = (NSL > 1) ? $clog2(NSL) : 1,
    localparam int CW     = $clog2(EW + 1),
    localparam int SCW    = $clog2(SLICE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              two_chunk,
    input  logic [EW-1:0]     calc0,
    input  logic [EW-1:0]     stored0,
    input  logic [EW-1:0]     calc1,
    input  logic [EW-1:0]     stored1,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              err_half,
    output logic [BYTE_W-1:0] err_byte,
    output logic [2:0]        err_bit,
    input  logic [IDX_W-1:0]  fix_idx,
    input  logic [7:0]        fix_in,
    output logic [7:0]        fix_out
);

    typedef struct packed {
        phase_e            phase;
        logic              half;
        logic [SEL_W-1:0]  slice;
        logic [CW-1:0]     ones;
        logic [EW-1:0]     calc;
        logic [EW-1:0]     stored;
        logic [EW-1:0]     calc_nx;
        logic [EW-1:0]     stored_nx;
        logic              two;
        ecc_status_e       status;
        logic              err_half;
        logic [BYTE_W-1:0] err_byte;
        logic [2:0]        err_bit;
        logic              done;
    } regs_t;

    regs_t s_d, s_q;

    logic [SCW-1:0]    slice_cnt;
    ecc_status_e       j_status;
    logic [BYTE_W-1:0] j_byte;
    logic [2:0]        j_bit;

    ecc_slice_pop #(.EW(EW), .SLICE_W(SLICE_W)) u_pop (
        .word (s_q.calc ^ s_q.stored),
        .sel  (s_q.slice),
        .cnt  (slice_cnt)
    );

    ecc_judge #(.PAR_W(PAR_W)) u_judge (
        .calc     (s_q.calc),
        .stored   (s_q.stored),
        .ones     (s_q.ones),
        .status   (j_status),
        .byte_idx (j_byte),
        .bit_idx  (j_bit)
    );

    ecc_byte_fix #(.IDX_W(IDX_W)) u_fix (
        .status    (s_q.status),
        .err_idx   ({s_q.err_half, s_q.err_byte}),
        .err_bit   (s_q.err_bit),
        .probe_idx (fix_idx),
        .din       (fix_in),
        .dout      (fix_out)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.calc      = calc0;
                    s_d.stored    = stored0;
                    s_d.calc_nx   = calc1;
                    s_d.stored_nx = stored1;
                    s_d.two       = two_chunk;
                    s_d.half      = 1'b0;
                    s_d.slice     = '0;
                    s_d.ones      = '0;
                    s_d.phase     = PH_COUNT;
                end
            end
            PH_COUNT: begin
                s_d.ones = s_q.ones + CW'(slice_cnt);
                if (s_q.slice == SEL_W'(NSL - 1)) begin
                    s_d.phase = PH_JUDGE;
                end else begin
                    s_d.slice = s_q.slice + 1'b1;
                end
            end
            PH_JUDGE: begin
                if (s_q.two && !s_q.half) begin
                    s_d.calc   = s_q.calc_nx;
                    s_d.stored = s_q.stored_nx;
                    s_d.half   = 1'b1;
                    s_d.slice  = '0;
                    s_d.ones   = '0;
                    s_d.phase  = PH_COUNT;
                end else begin
                    s_d.status   = j_status;
                    s_d.err_byte = j_byte;
                    s_d.err_bit  = j_bit;
                    s_d.err_half = (j_status == ST_FIXED) ? s_q.half : 1'b0;
                    s_d.done     = 1'b1;
                    s_d.phase    = PH_IDLE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = (s_q.phase != PH_IDLE);
    assign done     = s_q.done;
    assign status   = s_q.status;
    assign err_half = s_q.err_half;
    assign err_byte = s_q.err_byte;
    assign err_bit  = s_q.err_bit;

    // Serial count must match the syndrome weight when judged (R4, R5)
    assert_popcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_JUDGE) |-> (s_q.ones == CW'($countones(s_q.calc ^ s_q.stored))));

    // done lasts one cycle and follows a judge step (R8)
    assert_done_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    assert_done_after_judge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> $past(s_q.phase == PH_JUDGE));

    // Captured page mode is frozen while busy (R9)
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_COUNT) |=> $stable(s_q.two));

    // Result holds while counting (R10)
    assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_COUNT) |=> $stable(s_q.status));

    // No repair unless corrected (R6)
    assert_fix_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.status != ST_FIXED) |-> (fix_out == fix_in));

    // Check-word class carries no position (R3)
    assert_eccfield_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.status == ST_ECCBIT) |-> (err_byte == '0 && err_bit == '0 && !err_half));

endmodule

// File: tb/nand_ecc_corrector_test.sv
`timescale 1ns/1ps
module nand_ecc_corrector_test;

    localparam int LAT1 = (22 + 4 - 1) / 4 + 1;
    localparam int LAT2 = 2 * LAT1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        two_chunk = 1'b0;
    logic [21:0] calc0 = '0, stored0 = '0, calc1 = '0, stored1 = '0;
    logic        busy, done, err_half;
    logic [1:0]  status;
    logic [7:0]  err_byte;
    logic [2:0]  err_bit;
    logic [8:0]  fix_idx = '0;
    logic [7:0]  fix_in = '0;
    logic [7:0]  fix_out;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nand_ecc_corrector uut (
        .clk(clk), .rst_n(rst_n), .start(start), .two_chunk(two_chunk),
        .calc0(calc0), .stored0(stored0), .calc1(calc1), .stored1(stored1),
        .busy(busy), .done(done), .status(status), .err_half(err_half),
        .err_byte(err_byte), .err_bit(err_bit),
        .fix_idx(fix_idx), .fix_in(fix_in), .fix_out(fix_out)
    );

    // {calc, stored, status, byte, bit}
    localparam logic [56:0] VEC [12] = '{
        {22'h2AB3C1, 22'h2AB3C1, 2'b00, 8'h00, 3'd0},
        {22'h000015, 22'h000000, 2'b00, 8'h00, 3'd0},
        {22'h000000, 22'h000003, 2'b00, 8'h00, 3'd0},
        {22'h000000, 22'h000010, 2'b00, 8'h00, 3'd0},
        {22'h10F0F0, 22'h00F0F0, 2'b01, 8'h00, 3'd0},
        {22'h000401, 22'h000001, 2'b01, 8'h00, 3'd0},
        {(22'h0ABCDE ^ {~11'h4D5, 11'h4D5}), 22'h0ABCDE, 2'b10, 8'h9A, 3'd5},
        {(22'h155555 ^ {11'h7FF, 11'h000}), 22'h155555, 2'b10, 8'h00, 3'd0},
        {(22'h001234 ^ {11'h000, 11'h7FF}), 22'h001234, 2'b10, 8'hFF, 3'd7},
        {(22'h2A0A0A ^ 22'h000BFF), 22'h2A0A0A, 2'b11, 8'h00, 3'd0},
        {(22'h000F00 ^ 22'h000003), 22'h000F00, 2'b11, 8'h00, 3'd0},
        {(22'h3F0000 ^ 22'h3FFFFF), 22'h3F0000, 2'b11, 8'h00, 3'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [21:0] ca, input logic [21:0] sa,
                       input logic [21:0] cb, input logic [21:0] sb,
                       input logic two, output int lat);
        @(negedge clk);
        calc0 = ca; stored0 = sa; calc1 = cb; stored1 = sb;
        two_chunk = two; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        check(!done, "R8 done single pulse", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat;
        int dn;
        // R1 reset state
        fix_in = 8'hA5; fix_idx = 9'h000;
        repeat (3) @(negedge clk);
        check(status == 2'b00, "R1 status", status, 0);
        check(!done && !busy, "R1 done/busy", {done, busy}, 0);
        check(err_byte == 0 && err_bit == 0 && !err_half, "R1 indices", {err_half, err_byte, err_bit}, 0);
        check(fix_out == 8'hA5, "R1 fix passthrough", fix_out, 8'hA5);
        rst_n = 1'b1;

        // Vector table: R2..R5, latency R8
        for (int i = 0; i < 12; i++) begin
            string req;
            case (VEC[i][12:11])
                2'b00: req = "R2";
                2'b01: req = "R3";
                2'b10: req = "R4";
                default: req = "R5";
            endcase
            run(VEC[i][56:35], VEC[i][34:13], 22'h0, 22'h0, 1'b0, lat);
            check(status == VEC[i][12:11], {req, " status"}, status, VEC[i][12:11]);
            check(err_byte == VEC[i][10:3], {req, " byte"}, err_byte, VEC[i][10:3]);
            check(err_bit == VEC[i][2:0], {req, " bit"}, err_bit, VEC[i][2:0]);
            check(lat == LAT1, "R8 latency single", lat, LAT1);
            if (VEC[i][12:11] == 2'b01) begin
                fix_idx = 9'h000; fix_in = 8'h3C;
                #1 check(fix_out == 8'h3C, "R3 no repair", fix_out, 8'h3C);
            end
        end

        // R6/R10: repair at byte 0x9A bit 5
        run((22'h0ABCDE ^ {~11'h4D5, 11'h4D5}), 22'h0ABCDE, 22'h0, 22'h0, 1'b0, lat);
        repeat (5) @(negedge clk);
        check(status == 2'b10 && err_byte == 8'h9A, "R10 result held", {status, err_byte}, {2'b10, 8'h9A});
        fix_idx = 9'h09A; fix_in = 8'h00;
        #1 check(fix_out == 8'h20, "R6 repair hit", fix_out, 8'h20);
        fix_idx = 9'h09A; fix_in = 8'hFF;
        #1 check(fix_out == 8'hDF, "R6 repair hit inverted", fix_out, 8'hDF);
        fix_idx = 9'h09B; fix_in = 8'h00;
        #1 check(fix_out == 8'h00, "R6 index miss", fix_out, 0);
        fix_idx = 9'h19A;
        #1 check(fix_out == 8'h00, "R6 other half miss", fix_out, 0);

        // R7: repair in first half, clean second half -> clean
        run((22'h0ABCDE ^ {~11'h4D5, 11'h4D5}), 22'h0ABCDE, 22'h111111, 22'h111111, 1'b1, lat);
        check(status == 2'b00, "R7 last half wins", status, 0);
        check(lat == LAT2, "R8 latency double", lat, LAT2);
        fix_idx = 9'h09A; fix_in = 8'h00;
        #1 check(fix_out == 8'h00, "R7 no stale repair", fix_out, 0);

        // R7: clean first half, repair in second half
        run(22'h222222, 22'h222222, (22'h0ABCDE ^ {~11'h4D5, 11'h4D5}), 22'h0ABCDE, 1'b1, lat);
        check(status == 2'b10 && err_half && err_byte == 8'h9A && err_bit == 3'd5,
              "R7 second half repair", {status, err_half, err_byte, err_bit}, {2'b10, 1'b1, 8'h9A, 3'd5});
        fix_idx = 9'h19A; fix_in = 8'h01;
        #1 check(fix_out == 8'h21, "R7 offset 256", fix_out, 8'h21);
        fix_idx = 9'h09A;
        #1 check(fix_out == 8'h01, "R7 first half untouched", fix_out, 8'h01);

        // R9: start while busy ignored
        @(negedge clk);
        calc0 = 22'h000123; stored0 = 22'h000123; two_chunk = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(busy, "R8 busy during check", busy, 1);
        calc0 = 22'h000003; stored0 = 22'h000F00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dn = 0;
        for (int k = 0; k < 3 * LAT1; k++) begin
            @(negedge clk);
            if (done) dn++;
        end
        check(dn == 1, "R9 one done for two starts", dn, 1);
        check(status == 2'b00, "R9 result of accepted start", status, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule